// File: doc/BRIEF.md
# Parallel Port Host Controller with EPP Cycles

This block sits between a simple host register bus and the pins of a peripheral parallel port. It holds an output data register and a control register. It reports the handshake inputs through a status register. It drives three control pins. Each pin has a level output and an output enable, and active-low signalling is assumed on the wire.

Three modes share the same pins. Normal mode is the printer style: the control pins can only be pulled low, and the data bus is always driven. Bidirectional mode uses one control bit to release the data bus, so that data coming from the peripheral can be read. In EPP mode a host access to the data or address register becomes a timed hardware cycle with write, data-strobe and address-strobe phases. The peripheral can stretch that cycle with its wait input. A counter aborts the cycle if the peripheral never becomes ready.

The host issues one-cycle requests on `bus_req` and gets a one-cycle `bus_ready` pulse with the read data.

Top module: `pport_host`

## Requirements
- R1: After a synchronous reset the mode is normal. The following hold: `pd_out`=0x00, `pd_oe`=1, all three pin output enables are 0, `bus_ready`=0, `irq`=0, and the status register reads 0x00.
- R2: Register accesses get `bus_ready` in the cycle after the request edge. In normal mode the control register bits 2, 3 and 4 set the enables of the strobe, auto-feed and select-in pins. Those pins are driven at level 0 only. A data-register write appears on `pd_out` one cycle later, and `pd_oe` stays 1 whatever the value of bit 5.
- R3: In bidirectional mode, control bit 5 = 1 gives `pd_oe`=0, and data-register reads return `pd_in`. With bit 5 = 0, `pd_oe`=1 and reads return the stored output data.
- R4: An EPP write to address 0 (data) or address 3 (address) runs in two steps. First, for one cycle, the strobe pin goes low and the written byte is driven on `pd_out` with `pd_oe`=1. Then the auto-feed pin (for data) or the select-in pin (for address) goes low. With wait low, `bus_ready` follows two cycles after the first step.
- R5: An EPP read keeps the strobe pin high and `pd_oe`=0. It asserts the matching strobe and returns the value of `pd_in` that was present when the strobe ended.
- R6: In EPP mode all three pin output enables are 1, and the pins idle at level 1.
- R7: While the synchronised wait input (`busy_i`) is high, the strobe stays low and no `bus_ready` is given. The cycle ends within three cycles after wait falls.
- R8: If wait stays high for `TMO_CYCLES` (255) cycles of strobe, the cycle is aborted. The strobes are released, `bus_ready` comes 256 cycles after the first step, and status bit 0 is set.
- R9: Status (address 1) reads as follows: bit 0 is the timeout flag, bit 1 is the live wait input and bit 2 is the live acknowledge input, each after a two-flop synchroniser. A status read clears the timeout flag.
- R10: `irq` follows the synchronised `ack_i` in EPP mode only.
- R11: Requests made while an EPP cycle is in progress are ignored, so a control write cannot change the mode mid-cycle.
- R12: Control bits [1:0] select the mode: 00 is normal, 01 is bidirectional, 10 is EPP, and 11 acts as normal. The addresses are 0 data, 2 control (readable) and 3 EPP address, which reads 0x00 outside EPP mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | One-cycle access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid with bus_ready |
| bus_ready | output | 1 | One-cycle completion pulse |
| irq | output | 1 | Peripheral service request (EPP) |
| pd_out | output | 8 | Data bus output value |
| pd_oe | output | 1 | Data bus output enable |
| pd_in | input | 8 | Data bus input value |
| pin_stb_o | output | 1 | Strobe / write-indicator level |
| pin_stb_oe | output | 1 | Strobe pin enable |
| pin_afd_o | output | 1 | Auto-feed / data-strobe level |
| pin_afd_oe | output | 1 | Auto-feed pin enable |
| pin_sli_o | output | 1 | Select-in / address-strobe level |
| pin_sli_oe | output | 1 | Select-in pin enable |
| ack_i | input | 1 | Acknowledge / interrupt input |
| busy_i | input | 1 | Busy / wait input |

## Verification
Register reads and writes answer with `bus_ready` in the cycle right after the request edge. The bench issues every request at a falling edge and reads the answer at the next falling edge. EPP cycles are followed one falling edge at a time: the write indicator is checked after the request edge, the strobe one edge later, and ready two edges after the request with wait low, or exactly 256 edges after it on timeout. The handshake inputs pass through two flops. Each time `busy_i` or `ack_i` changes, the bench waits three cycles before it reads status or `irq`, and it bounds the end of a stretched cycle at three cycles after wait falls.

// File: rtl/pph_pkg.sv
package pph_pkg;

    localparam int DW = 8;

    typedef enum logic [1:0] {
        PM_NORMAL = 2'b00,
        PM_BIDIR  = 2'b01,
        PM_EPP    = 2'b10,
        PM_RSVD   = 2'b11
    } pmode_e;

    localparam logic [1:0] RA_DATA  = 2'd0;
    localparam logic [1:0] RA_STAT  = 2'd1;
    localparam logic [1:0] RA_CTRL  = 2'd2;
    localparam logic [1:0] RA_EADDR = 2'd3;

    localparam int CB_STB = 2;
    localparam int CB_AFD = 3;
    localparam int CB_SLI = 4;
    localparam int CB_DIR = 5;

    typedef enum logic [1:0] {
        EC_IDLE,
        EC_SETUP,
        EC_STRB,
        EC_END
    } ecyc_e;

    typedef struct packed {
        logic          wr;
        logic [1:0]    addr;
        logic [DW-1:0] data;
    } bus_req_t;

    typedef struct packed {
        logic lvl;
        logic oe;
    } odpin_t;

    function automatic pmode_e decode_mode(input logic [1:0] f);
        case (f)
            2'b01:   return PM_BIDIR;
            2'b10:   return PM_EPP;
            default: return PM_NORMAL;
        endcase
    endfunction

endpackage

// File: rtl/pph_sync.sv
module pph_sync #(
    parameter int STAGES = 2,
    parameter int W      = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst)         stg[g] <= '0;
            else if (g == 0) stg[g] <= d;
            else             stg[g] <= stg[(g == 0) ? 0 : g - 1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/pph_regs.sv
module pph_regs
    import pph_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          req,
    input  bus_req_t      breq,
    input  logic [DW-1:0] pd_in,
    input  logic          wait_s,
    input  logic          ack_s,
    input  logic          epp_busy,
    input  logic          tmo_set,
    output logic [DW-1:0] ctrl,
    output logic [DW-1:0] data_q,
    output pmode_e        mode,
    output logic          reg_ready,
    output logic [DW-1:0] reg_rdata,
    output logic          tmo_flag,
    output logic          epp_start
);
    logic accept, epp_target, reg_acc, stat_rd;

    assign mode       = decode_mode(ctrl[1:0]);
    assign accept     = req && !epp_busy;
    assign epp_target = (mode == PM_EPP) &&
                        (breq.addr == RA_DATA || breq.addr == RA_EADDR);
    assign epp_start  = accept && epp_target;
    assign reg_acc    = accept && !epp_target;
    assign stat_rd    = reg_acc && !breq.wr && breq.addr == RA_STAT;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl      <= '0;
            data_q    <= '0;
            reg_ready <= 1'b0;
            reg_rdata <= '0;
            tmo_flag  <= 1'b0;
        end else begin
            reg_ready <= reg_acc;
            if (reg_acc && breq.wr) begin
                if (breq.addr == RA_DATA) data_q <= breq.data;
                if (breq.addr == RA_CTRL) ctrl   <= breq.data;
            end
            if (reg_acc && !breq.wr) begin
                case (breq.addr)
                    RA_DATA: reg_rdata <= (mode == PM_BIDIR && ctrl[CB_DIR]) ? pd_in : data_q;
                    RA_STAT: reg_rdata <= {{(DW-3){1'b0}}, ack_s, wait_s, tmo_flag};
                    RA_CTRL: reg_rdata <= ctrl;
                    default: reg_rdata <= '0;
                endcase
            end
            if (tmo_set)      tmo_flag <= 1'b1;
            else if (stat_rd) tmo_flag <= 1'b0;
        end
    end

    // R9: a status read with no new timeout leaves the flag clear
    p_tmo_clear_r9: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && !tmo_set) |=> !tmo_flag);

    // R11: control never moves while an EPP cycle runs
    p_mode_hold_r11: assert property (@(posedge clk) disable iff (rst)
        epp_busy |=> $stable(ctrl));
endmodule

// File: rtl/pph_epp.sv
module pph_epp
    import pph_pkg::*;
#(
    parameter int TMO_CYCLES = 255
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  bus_req_t      breq,
    input  logic          wait_s,
    input  logic [DW-1:0] pd_in,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] rdata,
    output logic [DW-1:0] wlatch,
    output logic          wr_act,
    output logic          dstrb,
    output logic          astrb,
    output logic          drive,
    output logic          tmo_set
);
    localparam int CW = $clog2(TMO_CYCLES + 1);

    ecyc_e         state;
    logic [CW-1:0] cnt;
    logic          wr_q, addr_q, tmo_hit_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= EC_IDLE;
            cnt       <= '0;
            wr_q      <= 1'b0;
            addr_q    <= 1'b0;
            tmo_hit_q <= 1'b0;
            wlatch    <= '0;
            rdata     <= '0;
        end else begin
            case (state)
                EC_IDLE: if (start) begin
                    state     <= EC_SETUP;
                    cnt       <= '0;
                    tmo_hit_q <= 1'b0;
                    wr_q      <= breq.wr;
                    addr_q    <= (breq.addr == RA_EADDR);
                    if (breq.wr) wlatch <= breq.data;
                end
                EC_SETUP: state <= EC_STRB;
                EC_STRB: begin
                    if (!wait_s) begin
                        rdata <= pd_in;
                        state <= EC_END;
                    end else if (cnt == CW'(TMO_CYCLES - 1)) begin
                        tmo_hit_q <= 1'b1;
                        state     <= EC_END;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    state <= EC_IDLE;
                    wr_q  <= 1'b0;
                end
            endcase
        end
    end

    assign busy    = (state != EC_IDLE);
    assign done    = (state == EC_END);
    assign wr_act  = wr_q && busy;
    assign dstrb   = (state == EC_STRB) && !addr_q;
    assign astrb   = (state == EC_STRB) && addr_q;
    assign drive   = wr_q && busy;
    assign tmo_set = done && tmo_hit_q;

    // R4: only one strobe at a time
    p_one_strobe_r4: assert property (@(posedge clk) disable iff (rst)
        !(dstrb && astrb));

    // R7: normal completion only after wait was seen low
    p_ready_after_release_r7: assert property (@(posedge clk) disable iff (rst)
        (done && !tmo_hit_q) |-> $past(!wait_s));

    // R8: an abort only follows a wait that stayed high
    p_abort_on_wait_r8: assert property (@(posedge clk) disable iff (rst)
        (done && tmo_hit_q) |-> $past(wait_s));

    // R8: the strobe window never exceeds the limit
    p_tmo_bound_r8: assert property (@(posedge clk) disable iff (rst)
        (state == EC_STRB) |-> (cnt < CW'(TMO_CYCLES)));
endmodule

// File: rtl/pph_pins.sv
module pph_pins
    import pph_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  pmode_e        mode,
    input  logic          c_stb,
    input  logic          c_afd,
    input  logic          c_sli,
    input  logic          c_dir,
    input  logic [DW-1:0] data_q,
    input  logic [DW-1:0] wlatch,
    input  logic          wr_act,
    input  logic          dstrb,
    input  logic          astrb,
    input  logic          drive,
    output logic [DW-1:0] pd_out,
    output logic          pd_oe,
    output odpin_t        p_stb,
    output odpin_t        p_afd,
    output odpin_t        p_sli
);
    logic is_epp;
    assign is_epp = (mode == PM_EPP);

    always_comb begin
        pd_out = is_epp ? wlatch : data_q;
        case (mode)
            PM_BIDIR: pd_oe = !c_dir;
            PM_EPP:   pd_oe = drive;
            default:  pd_oe = 1'b1;
        endcase
        if (is_epp) begin
            p_stb = '{lvl: !wr_act, oe: 1'b1};
            p_afd = '{lvl: !dstrb,  oe: 1'b1};
            p_sli = '{lvl: !astrb,  oe: 1'b1};
        end else begin
            p_stb = '{lvl: 1'b0, oe: c_stb};
            p_afd = '{lvl: 1'b0, oe: c_afd};
            p_sli = '{lvl: 1'b0, oe: c_sli};
        end
    end

    // R2: outside EPP the control pins can only pull low
    p_od_low_r2: assert property (@(posedge clk) disable iff (rst)
        !is_epp |-> !(p_stb.lvl || p_afd.lvl || p_sli.lvl));

    // R6: EPP drives every control pin
    p_epp_drive_r6: assert property (@(posedge clk) disable iff (rst)
        is_epp |-> (p_stb.oe && p_afd.oe && p_sli.oe));
endmodule

// File: rtl/pport_host.sv
module pport_host
    import pph_pkg::*;
#(
    parameter int TMO_CYCLES  = 255,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_req,
    input  logic          bus_wr,
    input  logic [1:0]    bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          bus_ready,
    output logic          irq,
    output logic [DW-1:0] pd_out,
    output logic          pd_oe,
    input  logic [DW-1:0] pd_in,
    output logic          pin_stb_o,
    output logic          pin_stb_oe,
    output logic          pin_afd_o,
    output logic          pin_afd_oe,
    output logic          pin_sli_o,
    output logic          pin_sli_oe,
    input  logic          ack_i,
    input  logic          busy_i
);
    bus_req_t      breq;
    pmode_e        mode;
    logic [DW-1:0] ctrl, data_q, reg_rdata, epp_rdata, wlatch;
    logic          ack_s, wait_s, reg_ready, tmo_flag, epp_start;
    logic          epp_busy, epp_done, wr_act, dstrb, astrb, drive, tmo_set;
    odpin_t        p_stb, p_afd, p_sli;

    assign breq = '{wr: bus_wr, addr: bus_addr, data: bus_wdata};

    pph_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
        .clk(clk), .rst(rst), .d({ack_i, busy_i}), .q({ack_s, wait_s})
    );

    pph_regs u_regs (
        .clk(clk), .rst(rst), .req(bus_req), .breq(breq), .pd_in(pd_in),
        .wait_s(wait_s), .ack_s(ack_s), .epp_busy(epp_busy), .tmo_set(tmo_set),
        .ctrl(ctrl), .data_q(data_q), .mode(mode), .reg_ready(reg_ready),
        .reg_rdata(reg_rdata), .tmo_flag(tmo_flag), .epp_start(epp_start)
    );

    pph_epp #(.TMO_CYCLES(TMO_CYCLES)) u_epp (
        .clk(clk), .rst(rst), .start(epp_start), .breq(breq), .wait_s(wait_s),
        .pd_in(pd_in), .busy(epp_busy), .done(epp_done), .rdata(epp_rdata),
        .wlatch(wlatch), .wr_act(wr_act), .dstrb(dstrb), .astrb(astrb),
        .drive(drive), .tmo_set(tmo_set)
    );

    pph_pins u_pins (
        .clk(clk), .rst(rst), .mode(mode),
        .c_stb(ctrl[CB_STB]), .c_afd(ctrl[CB_AFD]), .c_sli(ctrl[CB_SLI]),
        .c_dir(ctrl[CB_DIR]), .data_q(data_q), .wlatch(wlatch),
        .wr_act(wr_act), .dstrb(dstrb), .astrb(astrb), .drive(drive),
        .pd_out(pd_out), .pd_oe(pd_oe), .p_stb(p_stb), .p_afd(p_afd), .p_sli(p_sli)
    );

    assign bus_ready  = reg_ready | epp_done;
    assign bus_rdata  = epp_done ? epp_rdata : reg_rdata;
    assign irq        = (mode == PM_EPP) && ack_s;
    assign pin_stb_o  = p_stb.lvl;
    assign pin_stb_oe = p_stb.oe;
    assign pin_afd_o  = p_afd.lvl;
    assign pin_afd_oe = p_afd.oe;
    assign pin_sli_o  = p_sli.lvl;
    assign pin_sli_oe = p_sli.oe;

    // R4: a data strobe of a write cycle starts only after the write indicator
    p_write_first_r4: assert property (@(posedge clk) disable iff (rst)
        (mode == PM_EPP && $fell(pin_afd_o) && !pin_stb_o) |-> $past(!pin_stb_o));

    // R2: register and EPP completions never collide
    p_single_ready_r2: assert property (@(posedge clk) disable iff (rst)
        !(reg_ready && epp_done));

    // R8: a raised timeout flag is always accompanied by a finished cycle
    p_tmo_with_ready_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(tmo_flag) |-> $past(bus_ready));
endmodule

// File: tb/pport_host_test.sv
`timescale 1ns/1ps
module pport_host_test;
    import pph_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_req = 1'b0, bus_wr = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0, pd_in = '0;
    logic ack_i = 1'b0, busy_i = 1'b0;
    logic [7:0] bus_rdata, pd_out;
    logic bus_ready, irq, pd_oe;
    logic pin_stb_o, pin_stb_oe, pin_afd_o, pin_afd_oe, pin_sli_o, pin_sli_oe;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    pport_host uut (
        .clk(clk), .rst(rst), .bus_req(bus_req), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready), .irq(irq),
        .pd_out(pd_out), .pd_oe(pd_oe), .pd_in(pd_in),
        .pin_stb_o(pin_stb_o), .pin_stb_oe(pin_stb_oe), .pin_afd_o(pin_afd_o),
        .pin_afd_oe(pin_afd_oe), .pin_sli_o(pin_sli_o), .pin_sli_oe(pin_sli_oe),
        .ack_i(ack_i), .busy_i(busy_i)
    );

    typedef struct packed {
        logic       wr;
        logic [1:0] addr;
        logic [7:0] wdata;
        logic [7:0] pdin;
        logic [7:0] exp_rd;
        logic [7:0] exp_pd;
        logic       exp_oe;
        logic [2:0] exp_pins;   // {sli, afd, stb} enables
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 2'd2, 8'h00, 8'h00, 8'h00, 8'h00, 1'b1, 3'b000},
        '{1'b1, 2'd0, 8'hA5, 8'h00, 8'h00, 8'hA5, 1'b1, 3'b000},
        '{1'b0, 2'd0, 8'h00, 8'h3C, 8'hA5, 8'hA5, 1'b1, 3'b000},
        '{1'b1, 2'd2, 8'h20, 8'h3C, 8'h00, 8'hA5, 1'b1, 3'b000},
        '{1'b0, 2'd0, 8'h00, 8'h3C, 8'hA5, 8'hA5, 1'b1, 3'b000},
        '{1'b1, 2'd2, 8'h21, 8'h3C, 8'h00, 8'hA5, 1'b0, 3'b000},
        '{1'b0, 2'd0, 8'h00, 8'h3C, 8'h3C, 8'hA5, 1'b0, 3'b000},
        '{1'b0, 2'd0, 8'h00, 8'hC3, 8'hC3, 8'hA5, 1'b0, 3'b000},
        '{1'b1, 2'd0, 8'h5A, 8'hC3, 8'h00, 8'h5A, 1'b0, 3'b000},
        '{1'b1, 2'd2, 8'h01, 8'hC3, 8'h00, 8'h5A, 1'b1, 3'b000},
        '{1'b0, 2'd0, 8'h00, 8'hFF, 8'h5A, 8'h5A, 1'b1, 3'b000},
        '{1'b0, 2'd2, 8'h00, 8'hFF, 8'h01, 8'h5A, 1'b1, 3'b000},
        '{1'b0, 2'd3, 8'h00, 8'hFF, 8'h00, 8'h5A, 1'b1, 3'b000},
        '{1'b1, 2'd2, 8'h23, 8'h00, 8'h00, 8'h5A, 1'b1, 3'b000},
        '{1'b0, 2'd0, 8'h00, 8'h00, 8'h5A, 8'h5A, 1'b1, 3'b000},
        '{1'b1, 2'd2, 8'h1C, 8'h00, 8'h00, 8'h5A, 1'b1, 3'b111}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic issue(input logic wr, input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0;
    endtask

    task automatic wait_ready(output int n, output logic [7:0] rd);
        n = 0;
        while (!bus_ready && n < 600) begin
            @(negedge clk);
            n++;
        end
        rd = bus_rdata;
    endtask

    task automatic access(input logic wr, input logic [1:0] a, input logic [7:0] d,
                          output logic [7:0] rd, output int n);
        issue(wr, a, d);
        wait_ready(n, rd);
    endtask

    function automatic logic [2:0] pin_lvls();
        return {pin_sli_o, pin_afd_o, pin_stb_o};
    endfunction

    function automatic logic [2:0] pin_oes();
        return {pin_sli_oe, pin_afd_oe, pin_stb_oe};
    endfunction

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        int n;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        chk("R1 pd_out", pd_out, 8'h00);
        chk("R1 pd_oe", pd_oe, 1);
        chk("R1 pin oe", pin_oes(), 3'b000);
        chk("R1 ready", bus_ready, 0);
        chk("R1 irq", irq, 0);
        access(1'b0, RA_STAT, 8'h00, rd, n);
        chk("R1 status", rd, 8'h00);
        chk("R2 reg latency", n, 0);

        // R2 R3 R12: register vector table
        for (int i = 0; i < NV; i++) begin
            pd_in = VECS[i].pdin;
            access(VECS[i].wr, VECS[i].addr, VECS[i].wdata, rd, n);
            if (!VECS[i].wr) chk("R3 R12 read data", rd, VECS[i].exp_rd);
            chk("R2 ready cycle", n, 0);
            @(negedge clk);
            chk("R2 R3 pd_out", pd_out, VECS[i].exp_pd);
            chk("R2 R3 pd_oe", pd_oe, VECS[i].exp_oe);
            chk("R2 pin oe", pin_oes(), VECS[i].exp_pins);
            chk("R2 pin level", pin_lvls(), 3'b000);
        end

        // R9 R10: live status bits and no irq outside EPP
        busy_i = 1'b1;
        repeat (3) @(negedge clk);
        access(1'b0, RA_STAT, 8'h00, rd, n);
        chk("R9 wait bit", rd, 8'h02);
        ack_i = 1'b1;
        repeat (3) @(negedge clk);
        access(1'b0, RA_STAT, 8'h00, rd, n);
        chk("R9 ack bit", rd, 8'h06);
        chk("R10 no irq in normal", irq, 0);
        ack_i = 1'b0; busy_i = 1'b0;
        repeat (3) @(negedge clk);

        // R6 R10: enter EPP
        access(1'b1, RA_CTRL, 8'h02, rd, n);
        @(negedge clk);
        chk("R6 oe", pin_oes(), 3'b111);
        chk("R6 idle level", pin_lvls(), 3'b111);
        ack_i = 1'b1;
        repeat (3) @(negedge clk);
        chk("R10 irq", irq, 1);
        ack_i = 1'b0;
        repeat (3) @(negedge clk);
        chk("R10 irq drop", irq, 0);

        // R4: EPP data write
        issue(1'b1, RA_DATA, 8'h96);
        chk("R4 write phase levels", pin_lvls(), 3'b110);
        chk("R4 write data", pd_out, 8'h96);
        chk("R4 write oe", pd_oe, 1);
        @(negedge clk);
        chk("R4 strobe phase levels", pin_lvls(), 3'b100);
        wait_ready(n, rd);
        chk("R4 ready cycle", n, 1);
        @(negedge clk);
        chk("R4 idle levels", pin_lvls(), 3'b111);
        chk("R4 bus released", pd_oe, 0);

        // R4: EPP address write uses select-in
        issue(1'b1, RA_EADDR, 8'h3D);
        @(negedge clk);
        chk("R4 addr strobe levels", pin_lvls(), 3'b010);
        chk("R4 addr data", pd_out, 8'h3D);
        wait_ready(n, rd);
        @(negedge clk);

        // R5: EPP address read
        pd_in = 8'h4E;
        issue(1'b0, RA_EADDR, 8'h00);
        chk("R5 no write indicator", pin_lvls(), 3'b111);
        chk("R5 oe", pd_oe, 0);
        @(negedge clk);
        chk("R5 addr strobe", pin_lvls(), 3'b011);
        wait_ready(n, rd);
        chk("R5 read data", rd, 8'h4E);
        @(negedge clk);

        // R7 R11: stretched data read with a control write attempted mid-cycle
        busy_i = 1'b1;
        pd_in = 8'h11;
        repeat (3) @(negedge clk);
        issue(1'b0, RA_DATA, 8'h00);
        begin
            bit early = 0;
            for (int k = 0; k < 10; k++) begin
                @(negedge clk);
                if (bus_ready) early = 1;
            end
            chk("R7 no early ready", early, 0);
        end
        chk("R7 strobe held", pin_afd_o, 0);
        issue(1'b1, RA_CTRL, 8'h00);
        chk("R11 no ready for ignored write", bus_ready, 0);
        busy_i = 1'b0;
        wait_ready(n, rd);
        chk("R7 release bound", (n <= 3) ? 1 : 0, 1);
        chk("R7 read data", rd, 8'h11);
        @(negedge clk);
        chk("R7 strobe released", pin_afd_o, 1);
        access(1'b0, RA_CTRL, 8'h00, rd, n);
        chk("R11 mode kept", rd, 8'h02);

        // R8 R9: timeout abort
        busy_i = 1'b1;
        repeat (3) @(negedge clk);
        issue(1'b1, RA_EADDR, 8'h77);
        wait_ready(n, rd);
        chk("R8 abort cycle", n, 256);
        @(negedge clk);
        chk("R8 strobes released", pin_lvls(), 3'b111);
        access(1'b0, RA_STAT, 8'h00, rd, n);
        chk("R8 R9 timeout flag", rd, 8'h03);
        access(1'b0, RA_STAT, 8'h00, rd, n);
        chk("R9 flag cleared", rd, 8'h02);
        busy_i = 1'b0;
        repeat (3) @(negedge clk);

        // R12: back to normal
        access(1'b1, RA_CTRL, 8'h00, rd, n);
        @(negedge clk);
        chk("R12 normal oe", pin_oes(), 3'b000);
        chk("R12 normal drive", pd_oe, 1);

        finished = 1;
        summary();
        $finish;
    end
endmodule